// File: doc/BRIEF.md
# Multiplexed Sample Output Formatter

This block sits between a converter's 14-bit result and a shared 14-line bidirectional pad bus. Each time a sample strobe arrives it captures the sample and the selected output format. It then presents the sample on the bus either as one full-width word or as a sequence of narrow slices on the upper lines. Narrow formats are 8, 7 or 4 lines wide. The 8- and 7-line formats send two slices per conversion period. The 4-line format sends four.

The bus itself is formed by the pads. The block supplies a data value and an enable for every line, and a line with its enable low is high impedance. A disable input releases the whole bus. A take-over request from the control port releases the upper eight lines, so that the control port can use them as an input while it writes a register. The parameter `PERIOD` is the number of clocks between sample strobes and must be a multiple of four. Slice boundaries are counted in clocks from the last strobe.

Top module: `sample_out_fmt`

## Requirements
- R1: While `out_dis` is 1, every bit of `out_en` is 0, whatever the other inputs are.
- R2: While `out_dis` is 0 and `ctl_take` is 1, `out_en[13:6]` is 0 and `out_en[5:0]` is all ones.
- R3: While both `out_dis` and `ctl_take` are 0, all 14 enables are 1, and every line the active format does not use carries 0.
- R4: Format code 00 (full width). From the clock after a strobe, `out_data` equals the captured 14-bit sample.
- R5: Format code 01 (8 lines). For the first `PERIOD/2` clocks after the strobe, sample bits 13:6 appear on lines 13:6. After that, sample bits 5:0 appear on lines 13:8 and lines 7:6 are 0. Lines 5:0 are always 0.
- R6: Format code 10 (7 lines). For the first `PERIOD/2` clocks, sample bits 13:7 appear on lines 13:7. After that, sample bits 6:0 appear on lines 13:7. Lines 6:0 are always 0.
- R7: Format code 11 (4 lines). The `PERIOD/4`-clock quarters after the strobe carry, in turn, sample bits 13:10, 9:6, 5:2, and then 1:0 followed by two zeros, all on lines 13:10. Lines 9:0 are always 0.
- R8: The format code is captured only on a strobe. A change of `fmt_sel` between strobes does not alter the sequence in progress.
- R9: The sample is captured only on a strobe. A change of `smp_data` between strobes does not alter the output.
- R10: A strobe restarts the sequence at its first slice, even when the previous sequence has not finished.
- R11: After reset the captured sample is 0 and the format is full width, so `out_data` is 0.
- R12: After the last slice of a narrow format, the output keeps that last slice until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | Sample strobe; captures the sample and the format |
| smp_data | input | 14 | Converted sample |
| fmt_sel | input | 2 | Format code: 00 full, 01 8-line, 10 7-line, 11 4-line |
| out_dis | input | 1 | Releases every bus line when 1 |
| ctl_take | input | 1 | Control port takes over lines 13:6 |
| out_data | output | 14 | Value for each bus line |
| out_en | output | 14 | Per-line drive enable; 0 means high impedance |

## Verification
The bench checks the slice boundaries at `PERIOD/2` and `PERIOD/4`. A wrong counter compare shows up there as a slice that arrives a clock early or late. It restarts a 4-line sequence partway through, which catches a counter that ignores the strobe. It also holds past the last slice, which catches a counter that wraps and replays the first slice. It changes the sample and the format code between strobes, and a design without a holding register passes those changes straight to the lines. Back-to-back strobes and release requests on both enable paths check that lines go to high impedance in the same cycle as the request.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

    localparam int SAMPLE_W = 14;
    localparam int CTL_LO   = 6;   // lowest line the control port borrows

    typedef enum logic [1:0] {
        FMT_FULL = 2'b00,
        FMT_MUX8 = 2'b01,
        FMT_MUX7 = 2'b10,
        FMT_MUX4 = 2'b11
    } fmt_mode_e;

    typedef struct packed {
        fmt_mode_e             mode;
        logic [SAMPLE_W-1:0]   data;
    } hold_t;

    // Place slice number idx of sample d on the bus for format m.
    function automatic logic [SAMPLE_W-1:0] place_slice(
        input fmt_mode_e           m,
        input logic [SAMPLE_W-1:0] d,
        input logic [1:0]          idx
    );
        logic [SAMPLE_W-1:0] r;
        r = '0;
        unique case (m)
            FMT_FULL: r = d;
            FMT_MUX8: r = idx[0] ? {d[5:0], 8'b0} : {d[13:6], 6'b0};
            FMT_MUX7: r = idx[0] ? {d[6:0], 7'b0} : {d[13:7], 7'b0};
            FMT_MUX4: begin
                unique case (idx)
                    2'd0: r = {d[13:10], 10'b0};
                    2'd1: r = {d[9:6],   10'b0};
                    2'd2: r = {d[5:2],   10'b0};
                    2'd3: r = {d[1:0],   12'b0};
                endcase
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fmt_phase_ctr.sv
module fmt_phase_ctr
    import fmt_pkg::*;
#(
    parameter int PERIOD = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      restart,
    input  fmt_mode_e mode,
    output logic [1:0] slice_idx
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
    localparam logic [CW-1:0] Q1   = CW'(PERIOD / 4);
    localparam logic [CW-1:0] Q2   = CW'(PERIOD / 2);
    localparam logic [CW-1:0] Q3   = CW'((3 * PERIOD) / 4);

    logic [CW-1:0] cnt_q;

    // Clock count since the last strobe, held at the period end.
    always_ff @(posedge clk) begin
        if (rst)             cnt_q <= '0;
        else if (restart)    cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        slice_idx = 2'd0;
        unique case (mode)
            FMT_FULL: slice_idx = 2'd0;
            FMT_MUX8,
            FMT_MUX7: slice_idx = (cnt_q < Q2) ? 2'd0 : 2'd1;
            FMT_MUX4: begin
                if      (cnt_q < Q1) slice_idx = 2'd0;
                else if (cnt_q < Q2) slice_idx = 2'd1;
                else if (cnt_q < Q3) slice_idx = 2'd2;
                else                 slice_idx = 2'd3;
            end
        endcase
    end
endmodule

// File: rtl/fmt_slicer.sv
module fmt_slicer
    import fmt_pkg::*;
(
    input  hold_t                hold,
    input  logic [1:0]           slice_idx,
    output logic [SAMPLE_W-1:0]  bus_val
);
    always_comb bus_val = place_slice(hold.mode, hold.data, slice_idx);
endmodule

// File: rtl/fmt_bus_enable.sv
module fmt_bus_enable
    import fmt_pkg::*;
(
    input  logic                 out_dis,
    input  logic                 ctl_take,
    output logic [SAMPLE_W-1:0]  line_en
);
    for (genvar g = 0; g < SAMPLE_W; g++) begin : g_line
        if (g >= CTL_LO) begin : g_shared
            assign line_en[g] = !out_dis && !ctl_take;
        end else begin : g_owned
            assign line_en[g] = !out_dis;
        end
    end
endmodule

// File: rtl/sample_out_fmt.sv
module sample_out_fmt
    import fmt_pkg::*;
#(
    parameter int PERIOD = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        smp_stb,
    input  logic [13:0] smp_data,
    input  logic [1:0]  fmt_sel,
    input  logic        out_dis,
    input  logic        ctl_take,
    output logic [13:0] out_data,
    output logic [13:0] out_en
);
    hold_t      hold_q;
    logic [1:0] slice_idx;

    // Holding register: sample and format move only on a strobe.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q.mode <= FMT_FULL;
            hold_q.data <= '0;
        end else if (smp_stb) begin
            hold_q.mode <= fmt_mode_e'(fmt_sel);
            hold_q.data <= smp_data;
        end
    end

    fmt_phase_ctr #(.PERIOD(PERIOD)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .restart   (smp_stb),
        .mode      (hold_q.mode),
        .slice_idx (slice_idx)
    );

    fmt_slicer u_slice (
        .hold      (hold_q),
        .slice_idx (slice_idx),
        .bus_val   (out_data)
    );

    fmt_bus_enable u_en (
        .out_dis   (out_dis),
        .ctl_take  (ctl_take),
        .line_en   (out_en)
    );
endmodule

// File: rtl/fmt_checker.sv
module fmt_checker
    import fmt_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        smp_stb,
    input logic [13:0] smp_data,
    input logic [1:0]  fmt_sel,
    input logic        out_dis,
    input logic        ctl_take,
    input logic [13:0] out_data,
    input logic [13:0] out_en,
    input hold_t       hold_q
);
    a_r1_disable_releases: assert property (@(posedge clk) disable iff (rst)
        out_dis |-> out_en == 14'h0000);

    a_r2_ctl_releases_upper: assert property (@(posedge clk) disable iff (rst)
        (!out_dis && ctl_take) |-> out_en == 14'h003F);

    a_r3_drive_all: assert property (@(posedge clk) disable iff (rst)
        (!out_dis && !ctl_take) |-> out_en == 14'h3FFF);

    a_r4_full_word: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && fmt_sel == 2'b00) |=> out_data == $past(smp_data));

    a_r5_mux8_low_zero: assert property (@(posedge clk) disable iff (rst)
        (hold_q.mode == FMT_MUX8) |-> out_data[5:0] == 6'b0);

    a_r6_mux7_low_zero: assert property (@(posedge clk) disable iff (rst)
        (hold_q.mode == FMT_MUX7) |-> out_data[6:0] == 7'b0);

    a_r7_mux4_low_zero: assert property (@(posedge clk) disable iff (rst)
        (hold_q.mode == FMT_MUX4) |-> out_data[9:0] == 10'b0);

    a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
        !smp_stb |=> $stable(hold_q));
endmodule

bind sample_out_fmt fmt_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .smp_stb  (smp_stb),
    .smp_data (smp_data),
    .fmt_sel  (fmt_sel),
    .out_dis  (out_dis),
    .ctl_take (ctl_take),
    .out_data (out_data),
    .out_en   (out_en),
    .hold_q   (hold_q)
);

// File: tb/test_sample_out_fmt.sv
`timescale 1ns/1ps
module test_sample_out_fmt;
    localparam int PERIOD = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_stb = 1'b0;
    logic [13:0] smp_data = '0;
    logic [1:0]  fmt_sel = 2'b00;
    logic        out_dis = 1'b0;
    logic        ctl_take = 1'b0;
    logic [13:0] out_data;
    logic [13:0] out_en;

    always #2.5 clk = ~clk;

    sample_out_fmt #(.PERIOD(PERIOD)) i_sample_out_fmt (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .smp_data(smp_data),
        .fmt_sel(fmt_sel), .out_dis(out_dis), .ctl_take(ctl_take),
        .out_data(out_data), .out_en(out_en)
    );

    typedef struct {
        logic [13:0] d;
        logic [13:0] en;
        string       dtag;
        string       etag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model of the requirements
    logic [13:0] m_data = '0;
    logic [1:0]  m_mode = 2'b00;
    int          m_cnt  = 0;

    function automatic logic [13:0] exp_word(logic [1:0] md, logic [13:0] d, int c);
        int idx;
        case (md)
            2'b01: begin idx = (c * 2) / PERIOD; return (d << (8 * idx)) & 14'h3FC0; end
            2'b10: begin idx = (c * 2) / PERIOD; return (d << (7 * idx)) & 14'h3F80; end
            2'b11: begin idx = (c * 4) / PERIOD; return (d << (4 * idx)) & 14'h3C00; end
            default: return d;
        endcase
    endfunction

    task automatic step(input bit r, input bit stb, input logic [13:0] d,
                        input logic [1:0] md, input bit dis, input bit take,
                        input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; smp_stb = stb; smp_data = d; fmt_sel = md;
        out_dis = dis; ctl_take = take;
        if (r) begin m_data = '0; m_mode = 2'b00; m_cnt = 0; end
        else if (stb) begin m_data = d; m_mode = md; m_cnt = 0; end
        else if (m_cnt < PERIOD - 1) m_cnt++;
        e.d  = exp_word(m_mode, m_data, m_cnt);
        e.en = dis ? 14'h0000 : (take ? 14'h003F : 14'h3FFF);
        e.etag = dis ? "R1" : (take ? "R2" : "R3");
        if (tag != "") e.dtag = tag;
        else if (!r && !stb && m_mode != 2'b00 && m_cnt == PERIOD - 1) e.dtag = "R12";
        else case (m_mode)
            2'b01: e.dtag = "R5";
            2'b10: e.dtag = "R6";
            2'b11: e.dtag = "R7";
            default: e.dtag = "R4";
        endcase
        q.push_back(e);
    endtask

    // Monitor: compare one expected item per cycle after the edge
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (out_data !== e.d) begin
                errors++;
                $display("FAIL %s data actual=%h expected=%h", e.dtag, out_data, e.d);
            end
            checks++;
            if (out_en !== e.en) begin
                errors++;
                $display("FAIL %s enable actual=%h expected=%h", e.etag, out_en, e.en);
            end
        end
    end

    // Send a sample and stay idle for n further cycles
    task automatic send(input logic [13:0] d, input logic [1:0] md, input int n,
                        input string tag);
        step(0, 1, d, md, 0, 0, tag);
        for (int i = 0; i < n; i++) step(0, 0, d, md, 0, 0, tag);
    endtask

    initial begin
        // R11: reset state
        for (int i = 0; i < 3; i++) step(1, 0, 14'h1555, 2'b11, 0, 0, "R11");
        step(0, 0, 14'h1555, 2'b11, 0, 0, "R11");

        // R4 full width, then R12-style hold
        send(14'h2A5C, 2'b00, PERIOD + 2, "R4");
        // R5, R6, R7 each run past the last slice (R12 tagged by model)
        send(14'h3A7F, 2'b01, PERIOD + 2, "");
        send(14'h1234, 2'b10, PERIOD + 2, "");
        send(14'h3C96, 2'b11, PERIOD + 3, "");

        // R8 and R9: change format and data between strobes
        step(0, 1, 14'h0F0F, 2'b01, 0, 0, "");
        for (int i = 0; i < PERIOD; i++)
            step(0, 0, 14'h3333 ^ 14'(i * 97), 2'(i), 0, 0, (i % 2) ? "R8" : "R9");

        // R10: restart a 4-line sequence partway through
        step(0, 1, 14'h2D4B, 2'b11, 0, 0, "R10");
        for (int i = 0; i < 3; i++) step(0, 0, 14'h2D4B, 2'b11, 0, 0, "R10");
        step(0, 1, 14'h1E87, 2'b11, 0, 0, "R10");
        for (int i = 0; i < PERIOD; i++) step(0, 0, 14'h1E87, 2'b11, 0, 0, "R10");

        // R1, R2, R3: enable paths during an 8-line sequence
        step(0, 1, 14'h3FFF, 2'b01, 0, 1, "");
        step(0, 0, 14'h3FFF, 2'b01, 1, 1, "");
        step(0, 0, 14'h3FFF, 2'b01, 1, 0, "");
        step(0, 0, 14'h3FFF, 2'b01, 0, 1, "");
        for (int i = 0; i < PERIOD; i++) step(0, 0, 14'h0000, 2'b00, i[0], i[1], "");

        // R10 back-to-back strobes, alternating formats
        for (int i = 0; i < 6; i++)
            step(0, 1, 14'h0A5 + 14'(i * 1111), 2'(i), 0, 0, "R10");
        send(14'h2001, 2'b10, PERIOD, "");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule